// File: doc/BRIEF.md
# Flash Region Write-Protection Guard

This block sits beside a two-bank flash controller and decides, for every page erase or program request, whether the target may be modified. Bank 0 is cut into 32 equal regions and bank 1 into 8. Each region has one protection bit, and a bit at 0 guards its region. The guard keeps its own latched copy of both protection words. It samples the option-byte storage values only in the first cycle after reset and on an explicit reload pulse, so edits to storage stay dormant until one of those two events.

Each request produces exactly one single-cycle response on the following clock: a grant or an error. An error also raises a sticky flag that software clears with a strobe. A page erase aimed at the option-byte region turns off all protection in both banks. Protection stays off until the next reload or reset, which latches whatever storage holds at that moment.

Top module: `flash_wp_guard`

## Requirements
- R1: In bank 0 (`req_bank`=0) the region index is offset bits [B0_AW-1:B0_AW-5], where B0_AW = log2(bank 0 size). The request is rejected when the latched bank 0 bit at that index is 0, and granted when it is 1.
- R2: In bank 1 (`req_bank`=1) the region index is offset bits [B1_AW-1:B1_AW-3], where B1_AW = log2(bank 1 size). The request is rejected when the latched bank 1 bit at that index is 0, and granted when it is 1.
- R3: Page erase (`req_erase`=1) and program (`req_erase`=0) are checked in the same way.
- R4: A request sampled on a rising edge produces a one-cycle `grant` or `err` after that edge, never both. No pulse appears without a request.
- R5: `wp_err` is set with every `err` pulse and cleared by `wp_err_clr`. When both happen on the same edge, the set wins.
- R6: Changes on `ob_wp0`/`ob_wp1` have no effect until a `reload` pulse. A request on the same edge as the reload is checked against the old words, and requests from the next edge on use the new ones.
- R7: During reset and in the first cycle after reset is released, nothing is protected. On that first edge the storage words are latched.
- R8: An erase request with `req_ob`=1 is granted and sets `prot_off`. While `prot_off` is 1 every request is granted. A program request with `req_ob`=1 is granted and leaves `prot_off` unchanged.
- R9: A `reload` clears `prot_off` and latches the current storage words. If an option-byte erase is requested on the same edge, that erase sets `prot_off` again.
- R10: Offset bits above the addressed bank's width are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_bank | input | 1 | Target bank (0 or 1) |
| req_offset | input | OFS_W | Byte offset within the bank |
| req_erase | input | 1 | 1 = page erase, 0 = program |
| req_ob | input | 1 | Request targets the option-byte region |
| ob_wp0 | input | 32 | Bank 0 protection word from option-byte storage |
| ob_wp1 | input | 8 | Bank 1 protection word from option-byte storage |
| reload | input | 1 | Pulse: latch the storage words |
| wp_err_clr | input | 1 | Pulse: clear the sticky error flag |
| grant | output | 1 | Request allowed (one cycle) |
| err | output | 1 | Request rejected (one cycle) |
| wp_err | output | 1 | Sticky rejection flag |
| prot_off | output | 1 | Protection disabled by option-byte erase |

## Verification
The hardest state to reach is the one where storage and the latched copy disagree. The bench changes storage without a reload and shows that the old protection still rejects requests. It then issues a request on the same edge as the reload and checks the edge where the new value takes effect. The first cycle after reset is reached by holding a request while reset is released with storage fully protecting. That request must be granted and the one after it rejected. The option-byte erase is followed by requests into regions known to be protected, and then by a reload that restores protection.

// File: rtl/flash_wp_guard.sv
module flash_wp_guard #(
  parameter int BANK0_BYTES = 1 << 17,
  parameter int BANK1_BYTES = 1 << 14,
  localparam int B0_AW = $clog2(BANK0_BYTES),
  localparam int B1_AW = $clog2(BANK1_BYTES),
  localparam int OFS_W = (B0_AW > B1_AW) ? B0_AW : B1_AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_bank,
  input  logic [OFS_W-1:0] req_offset,
  input  logic             req_erase,
  input  logic             req_ob,
  input  logic [31:0]      ob_wp0,
  input  logic [7:0]       ob_wp1,
  input  logic             reload,
  input  logic             wp_err_clr,
  output logic             grant,
  output logic             err,
  output logic             wp_err,
  output logic             prot_off
);

  logic [31:0] wp0_q;
  logic [7:0]  wp1_q;
  logic        boot_load;
  logic [4:0]  idx0;
  logic [2:0]  idx1;
  logic        bit_ok, deny, ob_wipe, latch_now;

  assign idx0      = req_offset[B0_AW-1 -: 5];
  assign idx1      = req_offset[B1_AW-1 -: 3];
  assign bit_ok    = req_bank ? wp1_q[idx1] : wp0_q[idx0];
  assign deny      = req_valid && !req_ob && !prot_off && !bit_ok;
  assign ob_wipe   = req_valid && req_ob && req_erase;
  assign latch_now = boot_load || reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp0_q     <= '1;
      wp1_q     <= '1;
      boot_load <= 1'b1;
    end else begin
      boot_load <= 1'b0;
      if (latch_now) begin
        wp0_q <= ob_wp0;
        wp1_q <= ob_wp1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant    <= 1'b0;
      err      <= 1'b0;
      wp_err   <= 1'b0;
      prot_off <= 1'b0;
    end else begin
      grant <= req_valid && !deny;
      err   <= deny;
      if (deny) wp_err <= 1'b1;
      else if (wp_err_clr) wp_err <= 1'b0;
      if (ob_wipe) prot_off <= 1'b1;
      else if (latch_now) prot_off <= 1'b0;
    end
  end

endmodule

// File: rtl/flash_wp_guard_chk.sv
module flash_wp_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_erase,
  input logic req_ob,
  input logic wp_err_clr,
  input logic grant,
  input logic err,
  input logic wp_err,
  input logic prot_off
);

  assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && err));

  assert_respond_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (grant || err));

  assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!grant && !err));

  assert_sticky_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> wp_err);

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_err_clr && !req_valid) |=> !wp_err);

  assert_wipe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ob && req_erase) |=> (prot_off && grant));

  assert_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prot_off |-> !err);

endmodule

bind flash_wp_guard flash_wp_guard_chk u_chk (.*);

// File: tb/flash_wp_guard_tb.sv
module flash_wp_guard_tb;

  localparam int B0 = 1 << 17;
  localparam int B1 = 1 << 14;
  localparam int OW = 17;
  localparam int R0 = B0 / 32;
  localparam int R1 = B1 / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_bank = 0, req_erase = 0, req_ob = 0;
  logic [OW-1:0] req_offset = '0;
  logic [31:0] ob_wp0 = '0;
  logic [7:0]  ob_wp1 = '0;
  logic reload = 0, wp_err_clr = 0;
  logic grant, err, wp_err, prot_off;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  flash_wp_guard #(.BANK0_BYTES(B0), .BANK1_BYTES(B1)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_offset(req_offset), .req_erase(req_erase), .req_ob(req_ob),
    .ob_wp0(ob_wp0), .ob_wp1(ob_wp1), .reload(reload), .wp_err_clr(wp_err_clr),
    .grant(grant), .err(err), .wp_err(wp_err), .prot_off(prot_off)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive one cycle of inputs, return {grant, err} visible after the edge.
  task automatic cyc(input logic v, input logic bank, input int ofs, input logic er,
                     input logic ob, input logic rl, input logic clr, output logic [1:0] ge);
    @(negedge clk);
    req_valid = v; req_bank = bank; req_offset = OW'(ofs); req_erase = er;
    req_ob = ob; reload = rl; wp_err_clr = clr;
    @(posedge clk); #2;
    ge = {grant, err};
    @(negedge clk);
    req_valid = 0; reload = 0; wp_err_clr = 0; req_ob = 0;
  endtask

  task automatic rq(string tag, input logic bank, input int ofs, input logic er,
                    input logic [1:0] exp);
    logic [1:0] ge;
    cyc(1, bank, ofs, er, 0, 0, 0, ge);
    chk(tag, 32'(ge), 32'(exp));
  endtask

  task automatic do_reload();
    logic [1:0] ge;
    cyc(0, 0, 0, 0, 0, 1, 0, ge);
  endtask

  task automatic clear_err();
    logic [1:0] ge;
    cyc(0, 0, 0, 0, 0, 0, 1, ge);
  endtask

  task automatic t_reset();
    logic [1:0] ge;
    #5;
    chk("R7 reset outputs", {28'b0, grant, err, wp_err, prot_off}, 32'h0);
    ob_wp0 = 32'h0; ob_wp1 = 8'h0;
    @(negedge clk);
    rst_n = 1'b1; req_valid = 1; req_bank = 0; req_offset = '0; req_erase = 1;
    @(posedge clk); #2;
    chk("R7 first cycle open", {30'b0, grant, err}, 32'h2);
    @(negedge clk); req_valid = 0;
    rq("R7 loaded after first edge", 0, 0, 1, 2'b01);
    chk("R5 sticky set", 32'(wp_err), 32'h1);
    clear_err();
    chk("R5 cleared", 32'(wp_err), 32'h0);
  endtask

  task automatic t_bank0();
    ob_wp0 = ~((32'h1 << 5) | (32'h1 << 31)); ob_wp1 = 8'hFF;
    do_reload();
    rq("R1 region5 erase", 0, 5*R0 + 12, 1, 2'b01);
    rq("R3 region5 program", 0, 5*R0 + 100, 0, 2'b01);
    rq("R1 region4 top", 0, 5*R0 - 1, 1, 2'b10);
    rq("R1 region31 last byte", 0, B0 - 1, 0, 2'b01);
    rq("R1 region6 first", 0, 6*R0, 0, 2'b10);
    rq("R2 bank1 open", 1, 5*R1, 1, 2'b10);
    clear_err();
  endtask

  task automatic t_bank1();
    logic [1:0] ge;
    ob_wp1 = 8'b1011_1110;
    do_reload();
    rq("R2 region0", 1, 0, 1, 2'b01);
    rq("R2 region1", 1, R1, 1, 2'b10);
    rq("R3 region6 program", 1, 6*R1 + 7, 0, 2'b01);
    rq("R2 region7", 1, B1 - 1, 0, 2'b10);
    rq("R10 high bits ignored", 1, (1 << 16) | (6*R1), 1, 2'b01);
    rq("R10 high bits open", 1, (1 << 15) | (7*R1), 1, 2'b10);
    cyc(0, 0, 0, 0, 0, 0, 0, ge);
    chk("R4 idle no pulse", 32'(ge), 32'h0);
    clear_err();
  endtask

  task automatic t_reload();
    logic [1:0] ge;
    ob_wp0 = 32'hFFFF_FFFF;
    rq("R6 no effect before reload", 0, 5*R0, 1, 2'b01);
    cyc(1, 0, 5*R0, 1, 0, 1, 0, ge);
    chk("R6 same-edge uses old", 32'(ge), 32'h1);
    rq("R6 new word active", 0, 5*R0, 1, 2'b10);
    @(posedge clk); #2;
    chk("R4 single-cycle pulse", {30'b0, grant, err}, 32'h0);
    clear_err();
  endtask

  task automatic t_ob();
    logic [1:0] ge;
    ob_wp0 = ~(32'h1 << 3); ob_wp1 = 8'hFE;
    do_reload();
    cyc(1, 0, 0, 0, 1, 0, 0, ge);
    chk("R8 ob program granted", {30'b0, ge}, 32'h2);
    chk("R8 ob program keeps protection", 32'(prot_off), 32'h0);
    cyc(1, 0, 0, 1, 1, 0, 0, ge);
    chk("R8 ob erase granted", {30'b0, ge}, 32'h2);
    chk("R8 prot_off set", 32'(prot_off), 32'h1);
    rq("R8 bank0 open", 0, 3*R0, 1, 2'b10);
    rq("R8 bank1 open", 1, 0, 0, 2'b10);
    chk("R8 no sticky error", 32'(wp_err), 32'h0);
    ob_wp0 = ~(32'h1 << 9);
    do_reload();
    chk("R9 reload clears prot_off", 32'(prot_off), 32'h0);
    rq("R9 new word latched", 0, 9*R0, 1, 2'b01);
    rq("R9 old bit gone", 0, 3*R0, 1, 2'b10);
    cyc(1, 0, 0, 1, 1, 1, 0, ge);
    chk("R9 erase wins over reload", 32'(prot_off), 32'h1);
    do_reload();
  endtask

  task automatic t_sticky();
    logic [1:0] ge;
    cyc(1, 0, 9*R0, 0, 0, 0, 1, ge);
    chk("R5 set beats clear", 32'(wp_err), 32'h1);
    rq("R5 flag holds on grant", 0, 0, 0, 2'b10);
    chk("R5 still set", 32'(wp_err), 32'h1);
    clear_err();
    chk("R5 clear strobe", 32'(wp_err), 32'h0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_bank0();
        t_bank1();
        t_reload();
        t_ob();
        t_sticky();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule